// File: doc/BRIEF.md
# Register Result Latency Scoreboard

This block sits at the issue point of an in-order pipeline. It tracks, for every architectural register and for one dedicated accumulator, how many cycles remain before a result still in flight can be read. Each cycle the issue stage offers one operation: up to two source register indices, each with its own enable, an optional destination, flags for reading and writing the accumulator, and an operation class. The class is integer ALU, floating-point, load or multiply-accumulate.

The block holds issue while any enabled source is still pending. Otherwise it accepts the operation and arms the destination's down-counter with the latency of that class. Multiply-accumulate operations can chain on the accumulator every cycle. Any other operation that reads the accumulator waits for the full latency. A cache miss elsewhere is presented as an external stall input. While it is high, every counter is frozen and the block reports a stall.

Top module: `lat_scoreboard`

## Requirements
- R1: After reset, and after any later reset, every register and the accumulator are ready, so no operation stalls on a source.
- R2: An integer ALU operation (class 0) makes its destination readable in the very next cycle.
- R3: A floating-point operation (class 1) accepted in cycle k stalls readers of its destination in cycles k+1 to k+3 and lets them issue in cycle k+4.
- R4: A load (class 2) accepted in cycle k lets another load issue in cycle k+1, stalls readers of its destination in cycle k+1, and frees them in cycle k+2.
- R5: A multiply-accumulate operation (class 3) that reads the accumulator never stalls on it, so such operations chain every cycle.
- R6: A non-accumulate operation that reads the accumulator waits until 4 cycles after the last accepted accumulator write.
- R7: A multiply-accumulate operation that writes a general register makes it readable 4 cycles after acceptance.
- R8: Register index 0 is never tracked and is always ready, even when it is written.
- R9: While the miss-stall input is high, stall is high, nothing is accepted, and every counter holds its value.
- R10: A source field whose enable is low has no effect on stall.
- R11: A shorter-latency write to a register that is still pending keeps the longer remaining wait.
- R12: A stalled operation records nothing about its destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An operation is offered this cycle |
| op_class | input | 2 | 0 integer, 1 floating-point, 2 load, 3 multiply-accumulate |
| src_a | input | $clog2(NREG) | First source index |
| src_a_en | input | 1 | First source is read |
| src_b | input | $clog2(NREG) | Second source index |
| src_b_en | input | 1 | Second source is read |
| dst | input | $clog2(NREG) | Destination index |
| dst_en | input | 1 | Destination is written |
| acc_rd | input | 1 | Operation reads the accumulator |
| acc_wr | input | 1 | Operation writes the accumulator |
| miss_stall | input | 1 | External miss stall; freezes all counters |
| stall | output | 1 | Issue is held this cycle |
| issue_ok | output | 1 | The offered operation is accepted this cycle |

## Verification
The bench looks for the exact cycle in which each dependent reader is released after floating-point, load, integer and accumulate producers. A design with an off-by-one latency would release a reader one cycle early or late. It replays a miss stall in the middle of a floating-point wait; a design that kept counting through the miss would release the reader early. It also covers a short write over a longer pending one, a stalled producer whose destination must stay clear, and a disabled source field that points at a busy register. A wrong design would free the reader early in the first case, invent a false hazard in the second, and stall spuriously in the third.

// File: rtl/lsb_pkg.sv
package lsb_pkg;
    typedef enum logic [1:0] {
        OPC_INT = 2'd0,
        OPC_FP  = 2'd1,
        OPC_LD  = 2'd2,
        OPC_MAC = 2'd3
    } op_class_t;
endpackage

// File: rtl/lsb_cnt.sv
module lsb_cnt #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          busy
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [CW-1:0] dec;

    always_comb begin
        dec  = (st_q.cnt == '0) ? '0 : st_q.cnt - 1'b1;
        st_d = st_q;
        if (!hold) begin
            st_d.cnt = dec;
            // keep whichever wait is longer
            if (load && (load_val > dec))
                st_d.cnt = load_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = (st_q.cnt != '0);
endmodule

// File: rtl/lsb_hazard.sv
module lsb_hazard #(
    parameter int NREG = 32,
    parameter int AW   = 5
) (
    input  logic [NREG-1:0] busy,
    input  logic            acc_busy,
    input  logic [AW-1:0]   src_a,
    input  logic            src_a_en,
    input  logic [AW-1:0]   src_b,
    input  logic            src_b_en,
    input  logic            acc_rd,
    input  logic            is_mac,
    output logic            hazard
);
    logic haz_a, haz_b, haz_acc;

    always_comb begin
        haz_a   = src_a_en && busy[src_a];
        haz_b   = src_b_en && busy[src_b];
        // accumulate ops forward along the accumulator chain
        haz_acc = acc_rd && !is_mac && acc_busy;
        hazard  = haz_a || haz_b || haz_acc;
    end
endmodule

// File: rtl/lat_scoreboard.sv
module lat_scoreboard #(
    parameter int NREG    = 32,
    parameter int LAT_INT = 1,
    parameter int LAT_FP  = 4,
    parameter int LAT_LD  = 2,
    parameter int LAT_MAC = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    issue_valid,
    input  logic [1:0]              op_class,
    input  logic [$clog2(NREG)-1:0] src_a,
    input  logic                    src_a_en,
    input  logic [$clog2(NREG)-1:0] src_b,
    input  logic                    src_b_en,
    input  logic [$clog2(NREG)-1:0] dst,
    input  logic                    dst_en,
    input  logic                    acc_rd,
    input  logic                    acc_wr,
    input  logic                    miss_stall,
    output logic                    stall,
    output logic                    issue_ok
);
    import lsb_pkg::*;

    localparam int AW      = $clog2(NREG);
    localparam int LAT_M1  = (LAT_INT > LAT_FP) ? LAT_INT : LAT_FP;
    localparam int LAT_M2  = (LAT_LD > LAT_MAC) ? LAT_LD : LAT_MAC;
    localparam int LAT_MAX = (LAT_M1 > LAT_M2) ? LAT_M1 : LAT_M2;
    localparam int CW      = (LAT_MAX > 2) ? $clog2(LAT_MAX) : 1;

    logic [NREG-1:0] busy;
    logic            acc_busy;
    logic            hazard;
    logic            is_mac;
    logic [CW-1:0]   arm_val;

    always_comb begin
        is_mac = (op_class_t'(op_class) == OPC_MAC);
        unique case (op_class_t'(op_class))
            OPC_INT: arm_val = CW'(LAT_INT - 1);
            OPC_FP:  arm_val = CW'(LAT_FP - 1);
            OPC_LD:  arm_val = CW'(LAT_LD - 1);
            default: arm_val = CW'(LAT_MAC - 1);
        endcase
    end

    lsb_hazard #(.NREG(NREG), .AW(AW)) u_haz (
        .busy     (busy),
        .acc_busy (acc_busy),
        .src_a    (src_a),
        .src_a_en (src_a_en),
        .src_b    (src_b),
        .src_b_en (src_b_en),
        .acc_rd   (acc_rd),
        .is_mac   (is_mac),
        .hazard   (hazard)
    );

    assign stall    = miss_stall || (issue_valid && hazard);
    assign issue_ok = issue_valid && !stall;

    // index 0 is hard-wired ready
    assign busy[0] = 1'b0;

    for (genvar r = 1; r < NREG; r++) begin : g_reg
        lsb_cnt #(.CW(CW)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .hold     (miss_stall),
            .load     (issue_ok && dst_en && (dst == AW'(r))),
            .load_val (arm_val),
            .busy     (busy[r])
        );
    end

    lsb_cnt #(.CW(CW)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (miss_stall),
        .load     (issue_ok && acc_wr),
        .load_val (arm_val),
        .busy     (acc_busy)
    );
endmodule

// File: rtl/lsb_chk.sv
module lsb_chk #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          issue_valid,
    input logic [1:0]    op_class,
    input logic [AW-1:0] src_a,
    input logic          src_a_en,
    input logic [AW-1:0] src_b,
    input logic          src_b_en,
    input logic [AW-1:0] dst,
    input logic          dst_en,
    input logic          acc_rd,
    input logic          acc_wr,
    input logic          miss_stall,
    input logic          stall,
    input logic          issue_ok
);
    assert_fp_reader_waits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(issue_ok && op_class == 2'd1 && dst_en && dst != '0)
         && issue_valid && src_a_en && src_a == $past(dst) && !miss_stall) |-> stall);

    assert_mac_chain_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && op_class == 2'd3 && acc_rd && !src_a_en && !src_b_en && !miss_stall)
        |-> !stall);

    assert_acc_reader_waits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(issue_ok && acc_wr && op_class == 2'd3)
         && issue_valid && acc_rd && op_class != 2'd3 && !miss_stall) |-> stall);

    assert_mac_gpr_waits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(issue_ok && op_class == 2'd3 && dst_en && dst != '0)
         && issue_valid && src_b_en && src_b == $past(dst) && !miss_stall) |-> stall);

    assert_zero_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && src_a_en && src_a == '0 && !src_b_en && !acc_rd && !miss_stall)
        |-> !stall);

    assert_hold_blocks_issue_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_stall && issue_valid) |-> !issue_ok);
endmodule

bind lat_scoreboard lsb_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .op_class    (op_class),
    .src_a       (src_a),
    .src_a_en    (src_a_en),
    .src_b       (src_b),
    .src_b_en    (src_b_en),
    .dst         (dst),
    .dst_en      (dst_en),
    .acc_rd      (acc_rd),
    .acc_wr      (acc_wr),
    .miss_stall  (miss_stall),
    .stall       (stall),
    .issue_ok    (issue_ok)
);

// File: tb/lat_scoreboard_tb.sv
module lat_scoreboard_tb;
    typedef struct packed {
        logic       v;
        logic [1:0] c;
        logic [4:0] a;
        logic       ae;
        logic [4:0] b;
        logic       be;
        logic [4:0] d;
        logic       de;
        logic       ar;
        logic       aw;
        logic       m;
        logic       exp;
        logic [3:0] req;
    } vec_t;

    function automatic vec_t mk(logic v, logic [1:0] c, logic [4:0] a, logic ae,
                                logic [4:0] b, logic be, logic [4:0] d, logic de,
                                logic ar, logic aw, logic m, logic exp, logic [3:0] req);
        mk = '{v, c, a, ae, b, be, d, de, ar, aw, m, exp, req};
    endfunction

    localparam int NV = 36;
    localparam vec_t VEC [NV] = '{
        mk(1,1, 1,1, 0,0,  3,1, 0,0, 0, 0, 3),  // 0  fp -> r3
        mk(1,0, 3,1, 0,0,  5,1, 0,0, 0, 1, 3),  // 1  R3 k+1 stall
        mk(1,0, 3,1, 0,0,  5,1, 0,0, 0, 1, 3),  // 2
        mk(1,0, 3,1, 0,0,  5,1, 0,0, 0, 1, 3),  // 3
        mk(1,0, 3,1, 0,0,  5,1, 0,0, 0, 0, 3),  // 4  R3 k+4 issue, int -> r5
        mk(1,0, 5,1, 0,0,  6,1, 0,0, 0, 0, 2),  // 5  R2 next cycle
        mk(1,2, 1,1, 0,0,  7,1, 0,0, 0, 0, 4),  // 6  load -> r7
        mk(1,2, 1,1, 0,0,  8,1, 0,0, 0, 0, 4),  // 7  R4 back-to-back load
        mk(1,0, 8,1, 0,0,  0,0, 0,0, 0, 1, 4),  // 8  R4 k+1 stall
        mk(1,0, 8,1, 7,1,  0,0, 0,0, 0, 0, 4),  // 9  R4 k+2 free
        mk(1,3, 1,1, 0,0,  0,0, 1,1, 0, 0, 5),  // 10 mac chain
        mk(1,3, 1,1, 0,0,  0,0, 1,1, 0, 0, 5),  // 11 R5
        mk(1,3, 1,1, 0,0,  0,0, 1,1, 0, 0, 5),  // 12 last acc write
        mk(1,3, 1,1, 0,0,  9,1, 1,0, 0, 0, 7),  // 13 final mac -> r9
        mk(1,0, 0,0, 0,0,  0,0, 1,0, 0, 1, 6),  // 14 R6 acc read stall
        mk(1,0, 9,1, 0,0,  0,0, 0,0, 0, 1, 7),  // 15 R7 stall
        mk(1,0, 0,0, 0,0,  0,0, 1,0, 0, 0, 6),  // 16 R6 free at +4
        mk(1,0, 9,1, 0,0,  0,0, 0,0, 0, 0, 7),  // 17 R7 free at +4
        mk(1,1, 1,1, 0,0,  0,1, 0,0, 0, 0, 8),  // 18 fp writes r0
        mk(1,0, 0,1, 0,0,  0,0, 0,0, 0, 0, 8),  // 19 R8 r0 ready
        mk(1,1, 1,1, 0,0, 11,1, 0,0, 0, 0,10),  // 20 fp -> r11
        mk(1,0,11,0, 2,1,  0,0, 0,0, 0, 0,10),  // 21 R10 disabled field
        mk(0,0, 0,0, 0,0,  0,0, 0,0, 1, 1, 9),  // 22 R9 miss
        mk(1,0, 2,1, 0,0,  0,0, 0,0, 1, 1, 9),  // 23 R9 miss
        mk(1,0,11,1, 0,0,  0,0, 0,0, 0, 1, 9),  // 24 R9 frozen count
        mk(1,0,11,1, 0,0,  0,0, 0,0, 0, 1, 9),  // 25
        mk(1,0,11,1, 0,0,  0,0, 0,0, 0, 0, 9),  // 26
        mk(1,1, 1,1, 0,0, 12,1, 0,0, 0, 0,11),  // 27 fp -> r12
        mk(1,0, 1,1, 0,0, 12,1, 0,0, 0, 0,11),  // 28 int -> r12
        mk(1,0,12,1, 0,0,  0,0, 0,0, 0, 1,11),  // 29 R11 long wait kept
        mk(1,0,12,1, 0,0,  0,0, 0,0, 0, 1,11),  // 30
        mk(1,0,12,1, 0,0,  0,0, 0,0, 0, 0,11),  // 31
        mk(1,1, 1,1, 0,0, 13,1, 0,0, 0, 0,12),  // 32 fp -> r13
        mk(1,1,13,1, 0,0, 14,1, 0,0, 0, 1,12),  // 33 stalled fp -> r14
        mk(1,0,14,1, 0,0,  0,0, 0,0, 0, 0,12),  // 34 R12 r14 clear
        mk(0,0, 0,0, 0,0,  0,0, 0,0, 0, 0, 1)   // 35 idle
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       issue_valid = 1'b0;
    logic [1:0] op_class = '0;
    logic [4:0] src_a = '0, src_b = '0, dst = '0;
    logic       src_a_en = 1'b0, src_b_en = 1'b0, dst_en = 1'b0;
    logic       acc_rd = 1'b0, acc_wr = 1'b0, miss_stall = 1'b0;
    logic       stall, issue_ok;
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    lat_scoreboard u_dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .op_class(op_class),
        .src_a(src_a), .src_a_en(src_a_en), .src_b(src_b), .src_b_en(src_b_en),
        .dst(dst), .dst_en(dst_en), .acc_rd(acc_rd), .acc_wr(acc_wr),
        .miss_stall(miss_stall), .stall(stall), .issue_ok(issue_ok)
    );

    task automatic drive(vec_t x);
        issue_valid = x.v;  op_class = x.c;
        src_a = x.a; src_a_en = x.ae; src_b = x.b; src_b_en = x.be;
        dst = x.d; dst_en = x.de; acc_rd = x.ar; acc_wr = x.aw; miss_stall = x.m;
    endtask

    task automatic step_check(vec_t x, string tag);
        @(posedge clk);
        #2 drive(x);
        #3;
        n_cmp++;
        if (stall !== x.exp || issue_ok !== (x.v && !x.exp)) begin
            n_bad++;
            $display("FAIL %s R%0d: stall=%b issue_ok=%b expected stall=%b issue_ok=%b",
                     tag, x.req, stall, issue_ok, x.exp, x.v && !x.exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        // R1: reading during reset and right after sees all ready
        step_check(mk(1,0, 3,1, 4,1, 0,0, 1,0, 0, 0, 1), "reset");
        @(posedge clk);
        #2 rst_n = 1'b1;
        for (int i = 0; i < NV; i++) step_check(VEC[i], $sformatf("vec%0d", i));
        // R1: reset clears a pending floating-point result
        step_check(mk(1,1, 1,1, 0,0, 15,1, 0,0, 0, 0, 1), "pre-reset fp");
        #1 rst_n = 1'b0;
        step_check(mk(0,0, 0,0, 0,0, 0,0, 0,0, 0, 0, 1), "in reset");
        #1 rst_n = 1'b1;
        step_check(mk(1,0,15,1, 0,0, 0,0, 0,0, 0, 0, 1), "R1 after reset");
        // R5: long chain of accumulates with a reader at the end
        for (int i = 0; i < 6; i++)
            step_check(mk(1,3, 0,0, 0,0, 0,0, 1,1, 0, 0, 5), "R5 chain");
        step_check(mk(1,2, 0,0, 0,0, 0,0, 1,0, 0, 1, 6), "R6 load reads acc");
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 2000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R1: run did not complete, actual=hung expected=done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule